// File: doc/BRIEF.md
# Interrupt Request and Vectoring Controller

This block collects four interrupt sources of a small 8-bit controller: two external pin interrupts and two timer overflows. Each single-cycle event pulse sets a request flag that stays set until software writes it back to zero. The flags sit in a sparse bit layout inside one byte-wide register. A second register holds a global service enable together with a 3-bit return-stack pointer.

When the global enable is set and any flag is pending, the block raises a vector request towards the CPU core. The core accepts it with an acknowledge. In that cycle the block presents the current return PC and the present stack pointer as a push. It then steps the pointer down by one and drops the global enable, so a second interrupt cannot nest. The core always enters at address 8. A return-from-interrupt strobe sets the enable again and steps the pointer back up.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the flag register (address 0xC8) reads 0x00, the control register (address 0xDF) reads 0x07 (enable 0, pointer 3'b111), and `vec_req_o` is 0.
- R2: A pulse on `ev_i[0]`, `ev_i[1]`, `ev_i[2]` or `ev_i[3]` sets flag bit 0, 1, 4 or 6 of address 0xC8 respectively, readable in the cycle after the pulse.
- R3: A flag is cleared only by a software write of 0 to its bit at 0xC8; hardware, including vector entry, never clears one.
- R4: When an event and a software write clearing the same flag fall in one cycle, the flag ends at 1.
- R5: Bits 2, 3, 5 and 7 of 0xC8 and bits 6:3 of 0xDF read 0 and ignore writes; any other address reads 0x00 and writes to it change nothing.
- R6: At 0xDF, bit 7 is the global enable and bits 2:0 are the stack pointer, both writable by software.
- R7: `vec_req_o` is 1 exactly when the global enable is 1 and at least one flag is 1; `vec_pc_o` is always 8.
- R8: In a cycle with `vec_req_o` and `vec_ack_i` both 1, `push_we_o` is 1, `push_addr_o` is the current pointer and `push_pc_o` equals `ret_pc_i`; the next cycle shows the pointer minus one (modulo 8) and the enable at 0.
- R9: A `reti_i` pulse sets the enable to 1 and adds one to the pointer (modulo 8).
- R10: A vector entry or `reti_i` overrides a software write to 0xDF in the same cycle; entry together with `reti_i` leaves the pointer unchanged and the enable at 0.
- R11: `vec_ack_i` without a pending `vec_req_o` produces no push and leaves 0xDF unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_i | input | 4 | Event pulses: ext0, ext1, timer0, timer1 |
| reg_addr_i | input | 8 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| ret_pc_i | input | 12 | Current return PC from the core |
| vec_req_o | output | 1 | Vector request to the core |
| vec_ack_i | input | 1 | Vector acknowledge from the core |
| vec_pc_o | output | 12 | Vector entry address |
| push_we_o | output | 1 | Return-stack write strobe |
| push_addr_o | output | 3 | Return-stack slot to write |
| push_pc_o | output | 12 | Return PC to store |
| reti_i | input | 1 | Return-from-interrupt strobe |

## Verification
The hardest situations to reach are the same-cycle collisions: an event against a clearing write of its own flag, and a vector entry or return against a software write of the control register, or against each other. The stimulus drives these strobes in one shared cycle. It then reads the registers back on the next cycle to see which side won. The pointer wrap from 0 to 7 is reached by writing pointer 0 with the enable set before an acknowledge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC      = 4;
  localparam int DW        = 8;
  localparam int SP_W      = 3;
  localparam int PC_W      = 12;
  localparam logic [DW-1:0] FLAG_ADDR = 8'hC8;
  localparam logic [DW-1:0] CTL_ADDR  = 8'hDF;
  localparam int VEC_ADDR  = 8;
  localparam int GIE_POS   = DW - 1;

  // bit position of each source inside the flag register
  function automatic int src_bit(input int s);
    case (s)
      0:       return 0;
      1:       return 1;
      2:       return 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic [DW-1:0] flag_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++) m[src_bit(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqv_rst_sync.sv
module irqv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irqv_flag_cell.sv
module irqv_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic q_o
);
  logic q_q, q_d, en;

  always_comb begin
    en  = set_i | wr_i;
    q_d = set_i ? 1'b1 : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= 1'b0;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/irqv_req_bank.sv
module irqv_req_bank
  import irqv_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [N-1:0] flags_o,
  output logic [W-1:0] view_o
);
  for (genvar s = 0; s < N; s++) begin : g_src
    localparam int POS = src_bit(s);
    irqv_flag_cell i_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ev_i[s]),
      .wr_i    (wr_i),
      .wdata_i (wdata_i[POS]),
      .q_o     (flags_o[s])
    );
  end

  always_comb begin
    view_o = '0;
    for (int s = 0; s < N; s++) view_o[src_bit(s)] = flags_o[s];
  end
endmodule

// File: rtl/irqv_stk_ctl.sv
module irqv_stk_ctl #(
  parameter int SPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sw_wr_i,
  input  logic           sw_gie_i,
  input  logic [SPW-1:0] sw_sp_i,
  input  logic           take_i,
  input  logic           reti_i,
  output logic           gie_o,
  output logic [SPW-1:0] sp_o
);
  logic           gie_q, gie_d;
  logic [SPW-1:0] sp_q, sp_d;
  logic           en;

  always_comb begin
    gie_d = gie_q;
    sp_d  = sp_q;
    en    = take_i | reti_i | sw_wr_i;
    if (take_i || reti_i) begin
      gie_d = reti_i & ~take_i;
      if (take_i && !reti_i)      sp_d = sp_q - SPW'(1);
      else if (reti_i && !take_i) sp_d = sp_q + SPW'(1);
    end else if (sw_wr_i) begin
      gie_d = sw_gie_i;
      sp_d  = sw_sp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      sp_q  <= '1;
    end else if (en) begin
      gie_q <= gie_d;
      sp_q  <= sp_d;
    end
  end

  assign gie_o = gie_q;
  assign sp_o  = sp_q;
endmodule

// File: rtl/irqv_vec_hs.sv
module irqv_vec_hs #(
  parameter int N   = 4,
  parameter int SPW = 3,
  parameter int PCW = 12,
  parameter int VEC = 8
) (
  input  logic           gie_i,
  input  logic [N-1:0]   flags_i,
  input  logic [SPW-1:0] sp_i,
  input  logic [PCW-1:0] ret_pc_i,
  input  logic           ack_i,
  output logic           req_o,
  output logic           take_o,
  output logic [PCW-1:0] vec_pc_o,
  output logic           push_we_o,
  output logic [SPW-1:0] push_addr_o,
  output logic [PCW-1:0] push_pc_o
);
  always_comb begin
    req_o       = gie_i & (|flags_i);
    take_o      = req_o & ack_i;
    vec_pc_o    = PCW'(VEC);
    push_we_o   = take_o;
    push_addr_o = sp_i;
    push_pc_o   = ret_pc_i;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int            N_SRC    = NSRC,
  parameter int            DATA_W   = DW,
  parameter int            SPTR_W   = SP_W,
  parameter int            PCADDR_W = PC_W,
  parameter logic [7:0]    A_FLAGS  = FLAG_ADDR,
  parameter logic [7:0]    A_CTRL   = CTL_ADDR,
  parameter int            VECTOR   = VEC_ADDR
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SRC-1:0]    ev_i,
  input  logic [7:0]          reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [PCADDR_W-1:0] ret_pc_i,
  output logic                vec_req_o,
  input  logic                vec_ack_i,
  output logic [PCADDR_W-1:0] vec_pc_o,
  output logic                push_we_o,
  output logic [SPTR_W-1:0]   push_addr_o,
  output logic [PCADDR_W-1:0] push_pc_o,
  input  logic                reti_i
);
  localparam int ENB = DATA_W - 1;

  logic                rst_sync_n;
  logic [N_SRC-1:0]    flags;
  logic [DATA_W-1:0]   flag_view;
  logic                gie;
  logic [SPTR_W-1:0]   sp;
  logic                take;
  logic                wr_flags, wr_ctrl;

  assign wr_flags = reg_wr_i && (reg_addr_i == A_FLAGS);
  assign wr_ctrl  = reg_wr_i && (reg_addr_i == A_CTRL);

  irqv_rst_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqv_req_bank #(.N(N_SRC), .W(DATA_W)) i_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ev_i    (ev_i),
    .wr_i    (wr_flags),
    .wdata_i (reg_wdata_i),
    .flags_o (flags),
    .view_o  (flag_view)
  );

  irqv_stk_ctl #(.SPW(SPTR_W)) i_stk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sw_wr_i  (wr_ctrl),
    .sw_gie_i (reg_wdata_i[ENB]),
    .sw_sp_i  (reg_wdata_i[SPTR_W-1:0]),
    .take_i   (take),
    .reti_i   (reti_i),
    .gie_o    (gie),
    .sp_o     (sp)
  );

  irqv_vec_hs #(.N(N_SRC), .SPW(SPTR_W), .PCW(PCADDR_W), .VEC(VECTOR)) i_hs (
    .gie_i       (gie),
    .flags_i     (flags),
    .sp_i        (sp),
    .ret_pc_i    (ret_pc_i),
    .ack_i       (vec_ack_i),
    .req_o       (vec_req_o),
    .take_o      (take),
    .vec_pc_o    (vec_pc_o),
    .push_we_o   (push_we_o),
    .push_addr_o (push_addr_o),
    .push_pc_o   (push_pc_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_FLAGS) begin
      reg_rdata_o = flag_view;
    end else if (reg_addr_i == A_CTRL) begin
      reg_rdata_o[ENB]          = gie;
      reg_rdata_o[SPTR_W-1:0]   = sp;
    end
  end
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
  import irqv_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] ev_i,
  input logic [NSRC-1:0] flags,
  input logic            gie,
  input logic [SP_W-1:0] sp,
  input logic            vec_req_o,
  input logic            vec_ack_i,
  input logic            reti_i,
  input logic            push_we_o,
  input logic [SP_W-1:0] push_addr_o,
  input logic            reg_wr_i,
  input logic [7:0]      reg_addr_i,
  input logic [DW-1:0]   reg_rdata_o
);
  localparam logic [DW-1:0] UNUSED = ~flag_mask();

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((flags & $past(ev_i)) == $past(ev_i))); // R2

  AST_NO_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == FLAG_ADDR) |=> ((flags & $past(flags)) == $past(flags))); // R3

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == FLAG_ADDR) |-> ((reg_rdata_o & UNUSED) == '0)); // R5

  AST_GATED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !vec_req_o); // R7

  AST_TAKE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_o && vec_ack_i && !reti_i) |=> (!gie && sp == SP_W'($past(push_addr_o) - 1'b1))); // R8

  AST_RETI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !(vec_req_o && vec_ack_i)) |=> (gie && sp == SP_W'($past(sp) + 1'b1))); // R9

  AST_NO_IDLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_req_o |-> !push_we_o); // R11
endmodule

bind irq_vector_ctrl irqv_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .ev_i        (ev_i),
  .flags       (flags),
  .gie         (gie),
  .sp          (sp),
  .vec_req_o   (vec_req_o),
  .vec_ack_i   (vec_ack_i),
  .reti_i      (reti_i),
  .push_we_o   (push_we_o),
  .push_addr_o (push_addr_o),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ev_i;
  logic [7:0]  reg_addr_i;
  logic        reg_wr_i;
  logic [7:0]  reg_wdata_i;
  logic [7:0]  reg_rdata_o;
  logic [11:0] ret_pc_i;
  logic        vec_req_o;
  logic        vec_ack_i;
  logic [11:0] vec_pc_o;
  logic        push_we_o;
  logic [2:0]  push_addr_o;
  logic [11:0] push_pc_o;
  logic        reti_i;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    int    kind;  // 0 rdata 1 req 2 push_we 3 push_addr 4 push_pc 5 vec_pc
    int    exp;
    string tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .ret_pc_i(ret_pc_i), .vec_req_o(vec_req_o), .vec_ack_i(vec_ack_i),
    .vec_pc_o(vec_pc_o), .push_we_o(push_we_o), .push_addr_o(push_addr_o),
    .push_pc_o(push_pc_o), .reti_i(reti_i)
  );

  // monitor: compare every queued expectation half a cycle after drive
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      int act;
      it = sb.pop_front();
      case (it.kind)
        0: act = int'(reg_rdata_o);
        1: act = int'(vec_req_o);
        2: act = int'(push_we_o);
        3: act = int'(push_addr_o);
        4: act = int'(push_pc_o);
        default: act = int'(vec_pc_o);
      endcase
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input int v, input string tag);
    item_t it;
    it.kind = kind; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a, input int v, input string tag);
    reg_addr_i = a;
    expect_item(0, v, tag);
    step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    step();
    reg_wr_i = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] e);
    ev_i = e;
    step();
    ev_i = '0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_i = '0; reg_addr_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    ret_pc_i = '0; vec_ack_i = 1'b0; reti_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    rd(8'hC8, 8'h00, "R1 flags after reset");
    expect_item(1, 0, "R1 no request after reset");
    rd(8'hDF, 8'h07, "R1 control after reset");

    // R2 sparse mapping, R7 gated while enable is 0
    pulse(4'b0001); rd(8'hC8, 8'h01, "R2 ext0 to bit0");
    pulse(4'b0100); rd(8'hC8, 8'h11, "R2 timer0 to bit4");
    pulse(4'b1000); rd(8'hC8, 8'h51, "R2 timer1 to bit6");
    pulse(4'b0010);
    expect_item(1, 0, "R7 no request with enable 0");
    rd(8'hC8, 8'h53, "R2 ext1 to bit1");

    // R5 unused bits, R3 software clear
    wr(8'hC8, 8'hFF); rd(8'hC8, 8'h53, "R5 unused flag bits ignore writes");
    wr(8'hC8, 8'h00); rd(8'hC8, 8'h00, "R3 software clear");
    wr(8'hDF, 8'h78); rd(8'hDF, 8'h00, "R5 R6 control unused bits ignored");
    wr(8'hDF, 8'h07);
    wr(8'h10, 8'hFF);
    rd(8'h10, 8'h00, "R5 other address reads zero");
    rd(8'hC8, 8'h00, "R5 stray write leaves flags");
    rd(8'hDF, 8'h07, "R5 stray write leaves control");

    // R4 event beats clearing write
    pulse(4'b0001);
    reg_addr_i = 8'hC8; reg_wdata_i = 8'h00; reg_wr_i = 1'b1; ev_i = 4'b0001;
    step();
    reg_wr_i = 1'b0; ev_i = '0;
    rd(8'hC8, 8'h01, "R4 event wins over clear");

    // R6 R7 R8 vector entry
    wr(8'hDF, 8'h87);
    expect_item(1, 1, "R7 request with enable and flag");
    expect_item(5, 8, "R7 vector address");
    rd(8'hDF, 8'h87, "R6 control readback");
    ret_pc_i = 12'h1A3; vec_ack_i = 1'b1;
    expect_item(2, 1, "R8 push strobe");
    expect_item(3, 7, "R8 push slot");
    expect_item(4, 12'h1A3, "R8 push pc");
    step();
    vec_ack_i = 1'b0;
    expect_item(1, 0, "R8 request drops after entry");
    rd(8'hDF, 8'h06, "R8 enable cleared pointer down");
    rd(8'hC8, 8'h01, "R3 entry keeps flag");

    // R9 return
    reti_i = 1'b1; step(); reti_i = 1'b0;
    expect_item(1, 1, "R9 request again after return");
    rd(8'hDF, 8'h87, "R9 enable set pointer up");

    // R11 ack with nothing pending
    wr(8'hC8, 8'h00);
    vec_ack_i = 1'b1;
    expect_item(2, 0, "R11 no push without request");
    step();
    vec_ack_i = 1'b0;
    rd(8'hDF, 8'h87, "R11 control unchanged");

    // R10 collisions
    pulse(4'b0010);
    reg_addr_i = 8'hDF; reg_wdata_i = 8'h03; reg_wr_i = 1'b1; vec_ack_i = 1'b1;
    step();
    reg_wr_i = 1'b0; vec_ack_i = 1'b0;
    rd(8'hDF, 8'h06, "R10 entry beats software write");
    reg_addr_i = 8'hDF; reg_wdata_i = 8'h00; reg_wr_i = 1'b1; reti_i = 1'b1;
    step();
    reg_wr_i = 1'b0; reti_i = 1'b0;
    rd(8'hDF, 8'h87, "R10 return beats software write");
    vec_ack_i = 1'b1; reti_i = 1'b1;
    step();
    vec_ack_i = 1'b0; reti_i = 1'b0;
    rd(8'hDF, 8'h07, "R10 entry with return keeps pointer");

    // R8 R9 pointer wrap
    wr(8'hDF, 8'h80);
    ret_pc_i = 12'h055; vec_ack_i = 1'b1;
    expect_item(3, 0, "R8 push slot zero");
    expect_item(4, 12'h055, "R8 push pc second");
    step();
    vec_ack_i = 1'b0;
    rd(8'hDF, 8'h07, "R8 pointer wraps down");
    reti_i = 1'b1; step(); reti_i = 1'b0;
    rd(8'hDF, 8'h80, "R9 pointer wraps up");
    rd(8'hC8, 8'h02, "R3 flag survives entries");

    step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule